// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is the output stage of a programmable sum-of-products logic array. It holds a row of identical cells. Each cell receives its own group of product terms from the AND array. From these it builds a pin drive value, a pin drive enable and a feedback bit that returns to the array. Two global mode bits are shared by every cell. Each cell also has a mode-select bit and a polarity bit of its own. Together these bits pick one of four behaviours per cell: registered output, combinatorial output, combinatorial I/O, or dedicated input.

Each cell owns a rising-edge flop. The flop clears on reset and can be preloaded from a test port, so that any state can be reached without walking the logic through it. The two outermost cells take their neighbour input from the shared enable pin and from the clock pin. Those two cells read the global bits differently when they choose their feedback source. The two innermost cells return no feedback when they act as plain combinatorial outputs.

Top module: `macrocell_bank`

## Requirements
- R1: The mode of each cell is decoded from {glb0_i, glb1_i, cell_sel_i[k]}. The value 010 selects registered. 100 selects combinatorial output. 011 and 111 select combinatorial I/O. 101 selects dedicated input. The remaining codes (000, 001, 110) are reserved. Cells in one bank may sit in different modes at the same time.
- R2: Cell k uses the product terms pterm_i[k*TERMS +: TERMS]. Its logic value is the OR of the terms in use. When cell_pol_i[k]=1 the value passes unchanged. When cell_pol_i[k]=0 it is inverted.
- R3: In combinatorial I/O mode, only terms 0..TERMS-2 feed the OR. The top term (index TERMS-1) alone drives pin_oe_o[k]. pin_o[k] shows the logic value at once. Feedback is the cell's own pin_in_i[k].
- R4: The flop captures on every rising clock edge, in every mode. In registered mode, pin_o[k] shows the logic value captured at the previous edge, and a change to the terms has no effect on it before the next edge. pin_oe_o[k] follows oe_i. Feedback is the flop content, which is the complement of the registered pin level.
- R5: While rst_ni is low, every flop holds 0. A cell in registered mode then drives pin_o high and returns feedback 0.
- R6: When pre_en_i is high at a rising edge, each cell's flop loads so that its registered pin level equals pre_data_i[k]. This takes the place of the logic value, in any mode.
- R7: In combinatorial output mode all TERMS terms are used and pin_oe_o is 1. Feedback is the neighbour input. The two middle cells (indices NUM_CELLS/2-1 and NUM_CELLS/2) return feedback 0 instead.
- R8: In dedicated input mode pin_oe_o is 0 and feedback is the neighbour input. Cell 0's neighbour is oe_i and cell NUM_CELLS-1's neighbour is clk_pin_i. A lower-half cell k takes pin_in_i[k-1]. An upper-half cell k takes pin_in_i[k+1].
- R9: End cells (0 and NUM_CELLS-1) pick feedback from glb0_i in place of glb1_i. With glb0_i=1 their feedback is the neighbour input, whatever cell_sel_i is. With glb0_i=0, cell_sel_i=0 gives the flop content and cell_sel_i=1 gives the own pin.
- R10: In a reserved mode pin_oe_o is 0 and feedback is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Flop clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glb0_i | input | 1 | Global mode bit 0 |
| glb1_i | input | 1 | Global mode bit 1 |
| cell_sel_i | input | NUM_CELLS | Per-cell mode select bit |
| cell_pol_i | input | NUM_CELLS | Per-cell polarity, 1 = active high |
| pterm_i | input | NUM_CELLS*TERMS | Product terms, TERMS per cell |
| oe_i | input | 1 | Shared output enable level, also cell 0 neighbour |
| clk_pin_i | input | 1 | Clock pin level used as data, neighbour of last cell |
| pin_in_i | input | NUM_CELLS | Levels seen at the cell pins |
| pre_en_i | input | 1 | Preload enable |
| pre_data_i | input | NUM_CELLS | Preload pin levels |
| pin_o | output | NUM_CELLS | Pin drive value |
| pin_oe_o | output | NUM_CELLS | Pin drive enable |
| fb_o | output | NUM_CELLS | Feedback to the logic array |

## Verification
The bench builds the block with NUM_CELLS=8 and TERMS=8. With eight cells, both end cells, both middle cells and ordinary cells in the lower and upper halves are all present at once. That puts every neighbour rule and every special feedback case within reach in one run. Eight terms per cell make the split between seven logic terms and one enable term visible: a pattern with only the top term set must give an active pin enable together with an empty OR.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

  typedef enum logic [2:0] {
    CM_REG,
    CM_COMB_OUT,
    CM_COMB_IO,
    CM_DED_IN,
    CM_RSVD
  } cell_mode_e;

  typedef enum logic [1:0] {
    FB_FLOP,
    FB_PIN,
    FB_ADJ,
    FB_ZERO
  } fb_src_e;

  function automatic cell_mode_e decode_mode(input logic g0, input logic g1, input logic l0);
    cell_mode_e m;
    case ({g0, g1, l0})
      3'b010:         m = CM_REG;
      3'b011, 3'b111: m = CM_COMB_IO;
      3'b100:         m = CM_COMB_OUT;
      3'b101:         m = CM_DED_IN;
      default:        m = CM_RSVD;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/olmc_sop.sv
module olmc_sop #(
  parameter int TERMS = 8
) (
  input  logic [TERMS-1:0] terms_i,
  input  logic             use_last_i,
  input  logic             pol_i,
  output logic             data_o,
  output logic             en_term_o
);
  localparam int LAST = TERMS - 1;

  logic sum;

  assign sum       = (|terms_i[LAST-1:0]) | (use_last_i & terms_i[LAST]);
  assign data_o    = sum ^ ~pol_i;
  assign en_term_o = terms_i[LAST];

endmodule

// File: rtl/olmc_fbsel.sv
module olmc_fbsel
  import olmc_pkg::*;
#(
  parameter bit IS_END = 1'b0,
  parameter bit IS_MID = 1'b0
) (
  input  cell_mode_e mode_i,
  input  logic       g0_i,
  input  logic       l0_i,
  output fb_src_e    src_o
);
  always_comb begin
    src_o = FB_ZERO;
    if (mode_i == CM_RSVD) begin
      src_o = FB_ZERO;
    end else if (IS_END) begin
      // end cells: global0 steers the feedback choice
      if (g0_i)      src_o = FB_ADJ;
      else if (l0_i) src_o = FB_PIN;
      else           src_o = FB_FLOP;
    end else begin
      case (mode_i)
        CM_REG:      src_o = FB_FLOP;
        CM_COMB_IO:  src_o = FB_PIN;
        CM_COMB_OUT: src_o = IS_MID ? FB_ZERO : FB_ADJ;
        CM_DED_IN:   src_o = FB_ADJ;
        default:     src_o = FB_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
  import olmc_pkg::*;
#(
  parameter int TERMS  = 8,
  parameter bit IS_END = 1'b0,
  parameter bit IS_MID = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             g0_i,
  input  logic             g1_i,
  input  logic             sel_i,
  input  logic             pol_i,
  input  logic [TERMS-1:0] terms_i,
  input  logic             oe_i,
  input  logic             pin_in_i,
  input  logic             adj_i,
  input  logic             pre_en_i,
  input  logic             pre_data_i,
  output logic             pin_o,
  output logic             pin_oe_o,
  output logic             fb_o
);
  cell_mode_e mode;
  fb_src_e    fb_src;
  logic       data;
  logic       en_term;
  logic       q_q;

  assign mode = decode_mode(g0_i, g1_i, sel_i);

  olmc_sop #(.TERMS(TERMS)) i_sop (
    .terms_i    (terms_i),
    .use_last_i (mode != CM_COMB_IO),
    .pol_i      (pol_i),
    .data_o     (data),
    .en_term_o  (en_term)
  );

  olmc_fbsel #(.IS_END(IS_END), .IS_MID(IS_MID)) i_fbsel (
    .mode_i (mode),
    .g0_i   (g0_i),
    .l0_i   (sel_i),
    .src_o  (fb_src)
  );

  // flop holds the complement of the registered pin level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_q <= 1'b0;
    else if (pre_en_i) q_q <= ~pre_data_i;
    else               q_q <= ~data;
  end

  assign pin_o = (mode == CM_REG) ? ~q_q : data;

  always_comb begin
    case (mode)
      CM_REG:      pin_oe_o = oe_i;
      CM_COMB_OUT: pin_oe_o = 1'b1;
      CM_COMB_IO:  pin_oe_o = en_term;
      default:     pin_oe_o = 1'b0;
    endcase
  end

  always_comb begin
    case (fb_src)
      FB_FLOP: fb_o = q_q;
      FB_PIN:  fb_o = pin_in_i;
      FB_ADJ:  fb_o = adj_i;
      default: fb_o = 1'b0;
    endcase
  end

  // R4
  reg_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_REG && $past(rst_ni) && !$past(pre_en_i)) |-> (pin_o == $past(data)));

  // R6
  preload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(pre_en_i) && mode == CM_REG) |-> (pin_o == $past(pre_data_i)));

  // R5
  reset_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && mode == CM_REG) |-> pin_o);

  // R8
  no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_DED_IN || mode == CM_RSVD) |-> !pin_oe_o);

  // R10
  rsvd_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == CM_RSVD) |-> !fb_o);

endmodule

// File: rtl/macrocell_bank.sv
module macrocell_bank #(
  parameter int NUM_CELLS = 8,
  parameter int TERMS     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           glb0_i,
  input  logic                           glb1_i,
  input  logic [NUM_CELLS-1:0]           cell_sel_i,
  input  logic [NUM_CELLS-1:0]           cell_pol_i,
  input  logic [NUM_CELLS*TERMS-1:0]     pterm_i,
  input  logic                           oe_i,
  input  logic                           clk_pin_i,
  input  logic [NUM_CELLS-1:0]           pin_in_i,
  input  logic                           pre_en_i,
  input  logic [NUM_CELLS-1:0]           pre_data_i,
  output logic [NUM_CELLS-1:0]           pin_o,
  output logic [NUM_CELLS-1:0]           pin_oe_o,
  output logic [NUM_CELLS-1:0]           fb_o
);
  localparam int MID_LO = NUM_CELLS / 2 - 1;
  localparam int MID_HI = NUM_CELLS / 2;
  localparam int LAST   = NUM_CELLS - 1;

  for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
    localparam bit IS_END = (k == 0) || (k == LAST);
    localparam bit IS_MID = (k == MID_LO) || (k == MID_HI);

    logic adj;

    if (k == 0) begin : g_adj_first
      assign adj = oe_i;
    end else if (k == LAST) begin : g_adj_last
      assign adj = clk_pin_i;
    end else if (k < MID_HI) begin : g_adj_lo
      assign adj = pin_in_i[k-1];
    end else begin : g_adj_hi
      assign adj = pin_in_i[k+1];
    end

    olmc_cell #(
      .TERMS  (TERMS),
      .IS_END (IS_END),
      .IS_MID (IS_MID)
    ) i_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .g0_i       (glb0_i),
      .g1_i       (glb1_i),
      .sel_i      (cell_sel_i[k]),
      .pol_i      (cell_pol_i[k]),
      .terms_i    (pterm_i[k*TERMS +: TERMS]),
      .oe_i       (oe_i),
      .pin_in_i   (pin_in_i[k]),
      .adj_i      (adj),
      .pre_en_i   (pre_en_i),
      .pre_data_i (pre_data_i[k]),
      .pin_o      (pin_o[k]),
      .pin_oe_o   (pin_oe_o[k]),
      .fb_o       (fb_o[k])
    );
  end

endmodule

// File: tb/test_macrocell_bank.sv
`timescale 1ns/1ps
module test_macrocell_bank;
  localparam int N  = 8;
  localparam int T  = 8;
  localparam int PW = N * T;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          glb0_i = 1'b0, glb1_i = 1'b1;
  logic [N-1:0]  cell_sel_i = '0, cell_pol_i = '1;
  logic [PW-1:0] pterm_i = '0;
  logic          oe_i = 1'b1, clk_pin_i = 1'b0;
  logic [N-1:0]  pin_in_i = '0;
  logic          pre_en_i = 1'b0;
  logic [N-1:0]  pre_data_i = '0;
  logic [N-1:0]  pin_o, pin_oe_o, fb_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [N-1:0] exp_lvl = '1;

  always #4 clk_i = ~clk_i;

  macrocell_bank #(.NUM_CELLS(N), .TERMS(T)) i_macrocell_bank (
    .clk_i, .rst_ni, .glb0_i, .glb1_i, .cell_sel_i, .cell_pol_i, .pterm_i,
    .oe_i, .clk_pin_i, .pin_in_i, .pre_en_i, .pre_data_i, .pin_o, .pin_oe_o, .fb_o
  );

  // 0 reg, 1 comb out, 2 comb io, 3 ded in, 4 reserved (R1)
  function automatic int mode_of(int k);
    case ({glb0_i, glb1_i, cell_sel_i[k]})
      3'b010:         return 0;
      3'b011, 3'b111: return 2;
      3'b100:         return 1;
      3'b101:         return 3;
      default:        return 4;
    endcase
  endfunction

  function automatic logic sop_of(int k);
    logic [T-1:0] t;
    logic s;
    t = pterm_i[k*T +: T];
    s = |t[T-2:0];
    if (mode_of(k) != 2) s = s | t[T-1];
    return cell_pol_i[k] ? s : ~s;
  endfunction

  function automatic logic adj_of(int k);
    if (k == 0)     return oe_i;
    if (k == N - 1) return clk_pin_i;
    if (k < N / 2)  return pin_in_i[k-1];
    return pin_in_i[k+1];
  endfunction

  function automatic logic [PW-1:0] rnd_terms();
    logic [PW-1:0] v;
    for (int i = 0; i < PW; i += 32)
      v[i +: 32] = $urandom & $urandom & $urandom & $urandom;
    return v;
  endfunction

  task automatic chk(string req, string what, int k, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cell %0d %s: got %b expected %b", req, k, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    #1;
    for (int k = 0; k < N; k++) begin
      int m;
      logic e_oe, e_fb, e_pin;
      bit is_end, is_mid;
      m = mode_of(k);
      is_end = (k == 0) || (k == N - 1);
      is_mid = (k == N / 2 - 1) || (k == N / 2);
      case (m)
        0: e_oe = oe_i;
        1: e_oe = 1'b1;
        2: e_oe = pterm_i[k*T + T - 1];
        default: e_oe = 1'b0;
      endcase
      if (m == 4) e_fb = 1'b0;
      else if (is_end) e_fb = glb0_i ? adj_of(k) : (cell_sel_i[k] ? pin_in_i[k] : ~exp_lvl[k]);
      else begin
        case (m)
          0: e_fb = ~exp_lvl[k];
          2: e_fb = pin_in_i[k];
          1: e_fb = is_mid ? 1'b0 : adj_of(k);
          default: e_fb = adj_of(k);
        endcase
      end
      e_pin = (m == 0) ? exp_lvl[k] : sop_of(k);
      chk(req, "pin_oe", k, pin_oe_o[k], e_oe);
      chk(req, "fb", k, fb_o[k], e_fb);
      if (m <= 2) chk(req, "pin", k, pin_o[k], e_pin);
    end
  endtask

  // one rising edge; model follows R4/R6
  task automatic tick();
    logic [N-1:0] nxt;
    for (int k = 0; k < N; k++) nxt[k] = pre_en_i ? pre_data_i[k] : sop_of(k);
    @(posedge clk_i);
    exp_lvl = nxt;
    @(negedge clk_i);
  endtask

  task automatic set_mode(logic g0, logic g1, logic [N-1:0] sel);
    glb0_i = g0;
    glb1_i = g1;
    cell_sel_i = sel;
  endtask

  task automatic t_reset();
    set_mode(1'b0, 1'b1, '0);
    pterm_i = '1;
    repeat (3) @(negedge clk_i);
    exp_lvl = '1;
    check_all("R5");
    rst_ni = 1'b1;
    check_all("R5");
    tick();
  endtask

  task automatic t_comb_out();
    set_mode(1'b1, 1'b0, '0);
    for (int i = 0; i < 8; i++) begin
      cell_pol_i = (i < 2) ? '1 : (i < 4) ? '0 : N'($urandom);
      pterm_i    = (i % 2 == 0) ? '0 : rnd_terms();
      pin_in_i   = N'($urandom);
      oe_i       = 1'($urandom);
      clk_pin_i  = 1'($urandom);
      check_all("R2/R7");
      tick();
    end
  endtask

  task automatic t_comb_io();
    for (int g = 0; g < 2; g++) begin
      set_mode(1'(g), 1'b1, '1);
      for (int i = 0; i < 6; i++) begin
        cell_pol_i = N'($urandom);
        // only the top term set: enable on, OR empty
        pterm_i    = (i == 0) ? {N{8'h80}} : rnd_terms();
        pin_in_i   = N'($urandom);
        oe_i       = 1'($urandom);
        clk_pin_i  = 1'($urandom);
        check_all("R3");
        tick();
      end
    end
  endtask

  task automatic t_registered();
    set_mode(1'b0, 1'b1, '0);
    for (int i = 0; i < 10; i++) begin
      cell_pol_i = N'($urandom);
      pterm_i    = rnd_terms();
      oe_i       = 1'(i % 3 != 0);
      pin_in_i   = N'($urandom);
      check_all("R4");
      tick();
    end
  endtask

  task automatic t_preload();
    set_mode(1'b0, 1'b1, '0);
    for (int i = 0; i < 4; i++) begin
      pterm_i    = rnd_terms();
      pre_en_i   = 1'b1;
      pre_data_i = (i == 0) ? 8'hA5 : N'($urandom);
      tick();
      pre_en_i   = 1'b0;
      check_all("R6");
      tick();
    end
    // preload while combinatorial, then reveal in registered mode
    set_mode(1'b1, 1'b0, '0);
    pre_en_i   = 1'b1;
    pre_data_i = 8'h3C;
    tick();
    pre_en_i   = 1'b0;
    set_mode(1'b0, 1'b1, '0);
    check_all("R6");
    tick();
  endtask

  task automatic t_ded_in();
    set_mode(1'b1, 1'b0, '1);
    for (int i = 0; i < 6; i++) begin
      pterm_i   = rnd_terms();
      pin_in_i  = N'($urandom);
      oe_i      = 1'($urandom);
      clk_pin_i = 1'($urandom);
      check_all("R8");
      tick();
    end
  endtask

  task automatic t_mixed();
    for (int i = 0; i < 6; i++) begin
      set_mode(1'b0, 1'b1, N'($urandom));
      cell_pol_i = N'($urandom);
      pterm_i    = rnd_terms();
      pin_in_i   = N'($urandom);
      oe_i       = 1'($urandom);
      check_all("R1");
      tick();
    end
  endtask

  task automatic t_end_cells();
    for (int i = 0; i < 6; i++) begin
      set_mode(1'(i % 2), 1'b1, (i < 2) ? '1 : N'($urandom));
      pterm_i   = rnd_terms();
      pin_in_i  = N'($urandom);
      oe_i      = 1'($urandom);
      clk_pin_i = 1'($urandom);
      check_all("R9");
      tick();
    end
  endtask

  task automatic t_reserved();
    for (int i = 0; i < 6; i++) begin
      if (i < 4) set_mode(1'b0, 1'b0, N'($urandom));
      else       set_mode(1'b1, 1'b1, '0);
      pterm_i   = rnd_terms();
      pin_in_i  = N'($urandom);
      oe_i      = 1'b1;
      clk_pin_i = 1'b1;
      check_all("R10");
      tick();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset();
    t_comb_out();
    t_comb_io();
    t_registered();
    t_preload();
    t_ded_in();
    t_mixed();
    t_end_cells();
    t_reserved();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): got timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule